// File: doc/BRIEF.md
# Read-Triggered Serial Shift-In Register

This block is a small CPU-side peripheral that collects a byte from a serial device one bit per system clock. It drives a shift clock out on one pin and samples serial data on another. The CPU sees one data register behind a chip select and a read strobe.

A read does two things at once. It returns whatever the register holds at that moment. It also starts a fresh 8-bit capture. Software therefore always receives the byte gathered by the previous operation. The first read after reset only seeds the pipeline and returns zero.

The CPU can poll the busy and done flags. It can also react to a one-cycle completion pulse that fires when the eighth bit lands. The serial input feeds the register at bit 0 and each shift moves the contents toward the MSB. After a full capture, the first bit received sits in bit 7.

Top module: `shift_in_reg`

## Requirements
- R1: After reset, busy_o, done_o and irq_o are 0, sclk_o is 1, and the first read returns 8'h00.
- R2: A read is a clock edge with cs_i=1 and rd_i=1. After that edge, busy_o is 1 and done_o is 0.
- R3: While busy, every system clock edge without a read shifts the register left by one. sdata_i enters bit 0, so the first of eight bits received ends in bit 7.
- R4: After exactly 8 shift edges, busy_o falls and done_o rises together. While idle and not read, the register contents do not change.
- R5: While cs_i=1 and rd_i=1, rdata_o shows the register contents captured before that read edge.
- R6: irq_o is high for exactly one cycle, on the cycle in which done_o first becomes 1.
- R7: sclk_o is 1 while idle. While busy it follows the system clock, so sdata_i is sampled on each rising edge of sclk_o.
- R8: A read during a running shift returns the partial contents, does not shift on that edge, and restarts the count. Eight more shifts then follow.
- R9: rd_i without cs_i has no effect: no restart, flags unchanged, and rdata_o is 0 whenever cs_i and rd_i are not both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_i | input | 1 | Chip select |
| rd_i | input | 1 | Read strobe |
| rdata_o | output | WIDTH | Read data, zero when not being read |
| busy_o | output | 1 | Capture in progress |
| done_o | output | 1 | Capture finished, cleared by the next read |
| irq_o | output | 1 | One-cycle completion pulse |
| sclk_o | output | 1 | Shift clock to the serial device |
| sdata_i | input | 1 | Serial data from the device |

## Verification
Several corner cases are targeted:
- A read mid-capture must return the partial byte and then run a full eight more shifts. A design that did not reset its counter would stop early and finish with a byte mixing two captures.
- The seeding read must return zero. A read edge must not also shift; if it did, every byte would be rotated by one bit.
- A read strobe without chip select must leave the capture state untouched. Leaking it would restart or clear done.
- An asynchronous reset in the middle of a capture must return sclk_o to its idle level.
- irq_o must last one cycle. A sticky or late pulse would not match the reference model.

// File: rtl/shift_in_pkg.sv
package shift_in_pkg;
  localparam int unsigned DEF_WIDTH = 8;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SHIFT,
    ST_DONE
  } sh_state_e;
endpackage

// File: rtl/shift_in_ctrl.sv
module shift_in_ctrl
  import shift_in_pkg::*;
#(
  parameter int unsigned WIDTH = DEF_WIDTH,
  localparam int unsigned CNT_W = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  output logic             shift_en_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             irq_o,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WIDTH - 1);

  sh_state_e        state_q;
  logic [CNT_W-1:0] cnt_q;
  logic             irq_q;
  logic             last_bit;

  assign last_bit = (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      irq_q   <= 1'b0;
    end else if (start_i) begin
      // read restarts regardless of state
      state_q <= ST_SHIFT;
      cnt_q   <= '0;
      irq_q   <= 1'b0;
    end else if (state_q == ST_SHIFT) begin
      cnt_q <= cnt_q + 1'b1;
      irq_q <= last_bit;
      if (last_bit) state_q <= ST_DONE;
    end else begin
      irq_q <= 1'b0;
    end
  end

  assign busy_o     = (state_q == ST_SHIFT);
  assign done_o     = (state_q == ST_DONE);
  assign irq_o      = irq_q;
  assign shift_en_o = busy_o & ~start_i;
  assign cnt_o      = cnt_q;
endmodule

// File: rtl/shift_in_dp.sv
module shift_in_dp
  import shift_in_pkg::*;
#(
  parameter int unsigned WIDTH = DEF_WIDTH
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             shift_en_i,
  input  logic             sdata_i,
  output logic [WIDTH-1:0] data_o
);
  logic [WIDTH-1:0] sr_q;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic nxt;
    if (i == 0) begin : g_lsb
      assign nxt = sdata_i;
    end else begin : g_up
      assign nxt = sr_q[i-1];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)         sr_q[i] <= 1'b0;
      else if (shift_en_i) sr_q[i] <= nxt;
    end
  end

  assign data_o = sr_q;
endmodule

// File: rtl/shift_in_reg.sv
module shift_in_reg
  import shift_in_pkg::*;
#(
  parameter int unsigned WIDTH = DEF_WIDTH,
  localparam int unsigned CNT_W = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cs_i,
  input  logic             rd_i,
  output logic [WIDTH-1:0] rdata_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             irq_o,
  output logic             sclk_o,
  input  logic             sdata_i
);
  logic             rd_hit;
  logic             shift_en;
  logic [WIDTH-1:0] data_q;
  logic [CNT_W-1:0] cnt_q;

  assign rd_hit = cs_i & rd_i;

  shift_in_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (rd_hit),
    .shift_en_o (shift_en),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .irq_o      (irq_o),
    .cnt_o      (cnt_q)
  );

  shift_in_dp #(.WIDTH(WIDTH)) u_dp (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .shift_en_i (shift_en),
    .sdata_i    (sdata_i),
    .data_o     (data_q)
  );

  assign rdata_o = rd_hit ? data_q : '0;
  // pin only: idles high, mirrors clock during capture
  assign sclk_o  = ~busy_o | clk_i;
endmodule

// File: rtl/shift_in_reg_chk.sv
module shift_in_reg_chk #(
  parameter int unsigned WIDTH = 8,
  localparam int unsigned CNT_W = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cs_i,
  input logic             rd_i,
  input logic [WIDTH-1:0] rdata_o,
  input logic             busy_o,
  input logic             done_o,
  input logic             irq_o,
  input logic             sclk_o,
  input logic             sdata_i,
  input logic [WIDTH-1:0] data_q,
  input logic [CNT_W-1:0] cnt_q
);
  // R2
  start_flags_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_i && rd_i) |=> (busy_o && !done_o));

  // R3
  shift_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !(cs_i && rd_i)) |=>
      (data_q == {$past(data_q[WIDTH-2:0]), $past(sdata_i)}));

  // R4
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !(cs_i && rd_i)) |=> $stable(data_q));

  // R4
  flag_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(busy_o && done_o));

  // R6
  irq_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);

  // R6
  irq_with_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (done_o && $rose(done_o)));

  // R7
  sclk_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> sclk_o);

  // R8
  restart_cnt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && cs_i && rd_i) |=> (cnt_q == '0 && $stable(data_q)));

  // R9
  bus_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cs_i && rd_i) |-> (rdata_o == '0));
endmodule

bind shift_in_reg shift_in_reg_chk #(.WIDTH(WIDTH)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .cs_i    (cs_i),
  .rd_i    (rd_i),
  .rdata_o (rdata_o),
  .busy_o  (busy_o),
  .done_o  (done_o),
  .irq_o   (irq_o),
  .sclk_o  (sclk_o),
  .sdata_i (sdata_i),
  .data_q  (data_q),
  .cnt_q   (cnt_q)
);

// File: tb/shift_in_reg_bench.sv
module shift_in_reg_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs = 1'b0;
  logic       rd = 1'b0;
  logic       sd = 1'b0;
  logic [7:0] rdata;
  logic       busy, done, irq, sclk;

  int checks = 0;
  int fails = 0;
  int cycles = 0;

  // behavioural reference
  int   m_left = 0;
  int   m_data = 0;
  bit   m_done = 0;
  bit   m_irq = 0;

  shift_in_reg u_shift_in_reg (
    .clk_i(clk), .rst_ni(rst_n), .cs_i(cs), .rd_i(rd), .rdata_o(rdata),
    .busy_o(busy), .done_o(done), .irq_o(irq), .sclk_o(sclk), .sdata_i(sd)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_left = 0; m_data = 0; m_done = 0; m_irq = 0;
    end else begin
      m_irq = 0;
      if (cs && rd) begin
        m_left = 8;
        m_done = 0;
      end else if (m_left > 0) begin
        m_data = ((m_data * 2) + int'(sd)) % 256;
        m_left = m_left - 1;
        if (m_left == 0) begin
          m_done = 1;
          m_irq  = 1;
        end
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles == 20000) begin
      checks++; fails++;
      $display("FAIL watchdog act=%0d exp=<20000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic compare();
    int exp_rd;
    exp_rd = (cs && rd) ? m_data : 0;
    chk(busy === (m_left > 0), "R2 busy", int'(busy), int'(m_left > 0));
    chk(done === m_done, "R4 done", int'(done), int'(m_done));
    chk(irq === m_irq, "R6 irq", int'(irq), int'(m_irq));
    chk(sclk === !(m_left > 0), "R7 sclk low phase", int'(sclk), int'(!(m_left > 0)));
    chk(rdata === 8'(exp_rd), "R5 rdata", int'(rdata), exp_rd);
  endtask

  task automatic step(input logic c, input logic r, input logic s);
    @(negedge clk);
    cs = c; rd = r; sd = s;
    #1;
    compare();
    @(posedge clk);
    #1;
    chk(sclk === 1'b1, "R7 sclk high phase", int'(sclk), 1);
  endtask

  task automatic read_expect(input logic [7:0] exp, input string tag);
    @(negedge clk);
    cs = 1; rd = 1; sd = 0;
    #1;
    chk(rdata === exp, tag, int'(rdata), int'(exp));
    compare();
    @(posedge clk);
  endtask

  task automatic feed(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) step(1'b0, 1'b0, b[i]);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk(busy === 0 && done === 0 && irq === 0, "R1 flags", {busy, done, irq}, 0);
    chk(sclk === 1, "R1 sclk idle", int'(sclk), 1);
    @(negedge clk);
    rst_n = 1;

    read_expect(8'h00, "R1 seeding read");
    feed(8'hA5);
    // R4 idle: toggling sdata must not alter contents
    for (int i = 0; i < 4; i++) step(1'b0, 1'b0, logic'(i % 2));
    chk(done === 1 && busy === 0, "R4 done held", {busy, done}, 1);
    read_expect(8'hA5, "R3 first bit lands in MSB");
    feed(8'h3C);
    step(1'b0, 1'b0, 1'b1);
    read_expect(8'h3C, "R5 previous byte returned");

    // R8 restart mid-capture
    step(1'b0, 1'b0, 1'b1);
    step(1'b0, 1'b0, 1'b0);
    step(1'b0, 1'b0, 1'b1);
    read_expect(8'hE5, "R8 partial contents");
    for (int i = 7; i >= 0; i--) begin
      step(1'b0, 1'b0, logic'((8'h96 >> i) & 1));
      chk(busy === (i != 0), "R8 full count after restart", int'(busy), int'(i != 0));
    end

    // R9 strobe without select
    for (int i = 0; i < 3; i++) step(1'b0, 1'b1, 1'b1);
    chk(busy === 0 && done === 1, "R9 no restart", {busy, done}, 1);
    step(1'b1, 1'b0, 1'b0);
    read_expect(8'h96, "R9 contents kept");
    feed(8'hFF);
    read_expect(8'hFF, "R3 all ones");
    feed(8'h01);
    read_expect(8'h01, "R3 last bit in LSB");

    // reset during capture
    step(1'b0, 1'b0, 1'b1);
    step(1'b0, 1'b0, 1'b0);
    @(negedge clk);
    rst_n = 0;
    #1;
    chk(busy === 0 && sclk === 1 && done === 0, "R1 reset mid-run", {busy, sclk, done}, 2);
    @(negedge clk);
    rst_n = 1;
    read_expect(8'h00, "R1 data cleared");
    feed(8'h5A);
    read_expect(8'h5A, "R5 after reset");
    step(1'b0, 1'b0, 1'b0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule